// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level slave front end of a serial NOR flash device. A bit-level shift stage hands it one received byte per transfer, along with a pulse that marks each new chip-select assertion. For every transfer the block returns a response byte at once. The block works out the opcode and collects however many address, mode and dummy bytes that opcode calls for. It keeps the write-enable latch and answers status and identification queries. It streams array data while the address wraps around the device size. Program and erase work goes to a separate array engine as single-cycle request pulses.

The bytes an opcode collects after itself depend on the opcode. For the dual and quad I/O reads they also depend on the manufacturer byte the device reports. Writing the status register needs the write-enable latch to be set, and the write then clears it. A single error pulse flags unknown opcodes and commands that are refused because write-enable is clear.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is idle with write-enable clear: the response byte is 0x00, no request pulse is raised, and a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Status read (0x05) returns one byte with the latch in bit 1 and all other bits 0, and then the block returns to idle.
- R3: Identification read (0x9F) returns the manufacturer byte, then the two device bytes (most significant first), then the two extended bytes when the extended identifier is nonzero. With the defaults the sequence is 0x20, 0xBA, 0x16, 0x4D, 0x00, and the byte after that is decoded as a new opcode.
- R4: After its opcode the block collects 3 bytes for 0x03, the program opcodes (0x02, 0xA2, 0x32) and the erase opcodes (0x20, 0x52, 0xD8). It collects 4 bytes for 0x0B, 0x3B and 0x6B. For 0xBB it collects 4 bytes when the manufacturer byte is 0xEF or 0x01 and 5 otherwise. For 0xEB it collects 6 bytes for those two manufacturers and 8 otherwise. The address is the first three collected bytes, most significant first.
- R5: In array-read state every transfer returns `arrReadData` for the current `arrAddr`. The address then steps by one, and it goes to 0 after DEV_SIZE-1.
- R6: In program state every received byte gives a `progValid` pulse one cycle later, carrying `progAddr` (the current address) and `progData` (the byte). The address then steps by one.
- R7: When the last address byte of 0x20, 0x52 or 0xD8 arrives with write-enable set, `eraseValid` pulses one cycle later with `eraseKind` 0, 1 or 2 and the collected address. Chip erase 0xC7 with write-enable set pulses one cycle after the opcode, with kind 3 and address 0. With write-enable clear, no erase pulse is raised and `errPulse` pulses instead.
- R8: Write status (0x01) with write-enable set collects one byte and then clears write-enable. With write-enable clear, `errPulse` pulses and the block stays idle, so the next byte is decoded as an opcode.
- R9: A `csAssert` pulse forces idle and abandons any command in progress. A byte presented in the same cycle as `csAssert` is ignored.
- R10: An unknown opcode causes one `errPulse` one cycle later and changes no state. Opcode 0x00 is ignored without an error.
- R11: The response byte is 0x00 in the idle, collecting and program states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csAssert | input | 1 | One-cycle pulse at each chip-select assertion |
| rxValid | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| txByte | output | 8 | Response byte for the transfer in this cycle |
| arrAddr | output | 24 | Current array address |
| arrReadData | input | 8 | Array byte at `arrAddr` (combinational) |
| progValid | output | 1 | Program request pulse |
| progAddr | output | 24 | Program address |
| progData | output | 8 | Program data byte |
| eraseValid | output | 1 | Erase request pulse |
| eraseKind | output | 2 | 0 small block, 1 mid block, 2 sector, 3 whole chip |
| eraseAddr | output | 24 | Erase address |
| errPulse | output | 1 | Refused or unknown command |

## Verification
The bench targets the byte-count boundaries. A design that collects 4 bytes for 0xBB, or 6 for 0xEB, under the default manufacturer would start returning array data one transfer early or two transfers early, and would read from the wrong address. It steps a read across DEV_SIZE-1: a missing wrap would return data from beyond the device. It sends status reads after gated and refused write-status and erase commands. A latch that is not cleared, or a command that is not refused, shows up as a wrong status byte or a stray erase pulse. It also sends a chip-select pulse in the middle of a command and together with a byte. A design that lets that byte through would set write-enable or produce stale responses.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [2:0] {ST_IDLE, ST_COLLECT, ST_PROG, ST_READ, ST_FIXED} seqState_e;
  typedef enum logic [1:0] {RS_ZERO, RS_ARRAY, RS_STATUS, RS_ID} respSel_e;
  typedef enum logic [1:0] {EK_SMALL, EK_MID, EK_SECTOR, EK_CHIP} eraseKind_e;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_WRST  = 8'h01;
  localparam logic [7:0] OP_PROG1 = 8'h02;
  localparam logic [7:0] OP_RD    = 8'h03;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_RDF   = 8'h0B;
  localparam logic [7:0] OP_ERS   = 8'h20;
  localparam logic [7:0] OP_PROG4 = 8'h32;
  localparam logic [7:0] OP_RD2O  = 8'h3B;
  localparam logic [7:0] OP_ERM   = 8'h52;
  localparam logic [7:0] OP_RD4O  = 8'h6B;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_PROG2 = 8'hA2;
  localparam logic [7:0] OP_RD2IO = 8'hBB;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
  localparam logic [7:0] OP_ERSEC = 8'hD8;
  localparam logic [7:0] OP_RD4IO = 8'hEB;

  typedef struct packed {
    logic       shiftAddr;
    logic       advRead;
    logic       advProg;
    logic       eraseReq;
    eraseKind_e eraseKind;
    logic       errReq;
    respSel_e   respSel;
    logic [2:0] fixIdx;
  } seqStrobe_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter logic [7:0] MFR_ID  = 8'h20,
  parameter bit         HAS_EXT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csAssert,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output seqState_e  stateQ,
  output logic       welQ,
  output seqStrobe_t strb
);
  localparam bit SHORT_IO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);
  localparam logic [2:0] ID_LEN = HAS_EXT ? 3'd5 : 3'd3;

  seqState_e  stateD;
  logic [7:0] cmdQ, cmdD;
  logic [3:0] needQ, needD, cntQ, cntD, cntNext;
  logic [2:0] fixIdxQ, fixIdxD, fixLenQ, fixLenD, fixNext;
  logic       welD;

  function automatic logic [3:0] collectLen(input logic [7:0] op);
    case (op)
      OP_RD, OP_PROG1, OP_PROG2, OP_PROG4, OP_ERS, OP_ERM, OP_ERSEC: return 4'd3;
      OP_RDF, OP_RD2O, OP_RD4O: return 4'd4;
      OP_RD2IO: return SHORT_IO ? 4'd4 : 4'd5;
      OP_RD4IO: return SHORT_IO ? 4'd6 : 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic isRead(input logic [7:0] op);
    return op inside {OP_RD, OP_RDF, OP_RD2O, OP_RD4O, OP_RD2IO, OP_RD4IO};
  endfunction

  function automatic logic isProg(input logic [7:0] op);
    return op inside {OP_PROG1, OP_PROG2, OP_PROG4};
  endfunction

  assign cntNext = cntQ + 4'd1;
  assign fixNext = fixIdxQ + 3'd1;

  always_comb begin
    strb    = '0;
    stateD  = stateQ;
    cmdD    = cmdQ;
    needD   = needQ;
    cntD    = cntQ;
    fixIdxD = fixIdxQ;
    fixLenD = fixLenQ;
    welD    = welQ;
    strb.fixIdx = fixIdxQ;
    case (stateQ)
      ST_READ:  strb.respSel = RS_ARRAY;
      ST_FIXED: strb.respSel = (cmdQ == OP_RDST) ? RS_STATUS : RS_ID;
      default:  strb.respSel = RS_ZERO;
    endcase
    if (csAssert) begin
      stateD  = ST_IDLE;
      cntD    = '0;
      fixIdxD = '0;
    end else if (rxValid) begin
      case (stateQ)
        ST_IDLE: begin
          cmdD    = rxByte;
          cntD    = '0;
          fixIdxD = '0;
          if (collectLen(rxByte) != 4'd0) begin
            needD  = collectLen(rxByte);
            stateD = ST_COLLECT;
          end else begin
            case (rxByte)
              OP_WRST: if (welQ) begin
                needD  = 4'd1;
                stateD = ST_COLLECT;
              end else strb.errReq = 1'b1;
              OP_WDIS: welD = 1'b0;
              OP_WEN:  welD = 1'b1;
              OP_RDST: begin fixLenD = 3'd1; stateD = ST_FIXED; end
              OP_RDID: begin fixLenD = ID_LEN; stateD = ST_FIXED; end
              OP_CHIP: if (welQ) begin
                strb.eraseReq  = 1'b1;
                strb.eraseKind = EK_CHIP;
              end else strb.errReq = 1'b1;
              OP_NOP: ;
              default: strb.errReq = 1'b1;
            endcase
          end
        end
        ST_COLLECT: begin
          strb.shiftAddr = (cntQ < 4'd3);
          cntD = cntNext;
          if (cntNext == needQ) begin
            stateD = ST_IDLE;
            if (isRead(cmdQ)) stateD = ST_READ;
            else if (isProg(cmdQ)) stateD = ST_PROG;
            else if (cmdQ == OP_WRST) welD = 1'b0;
            else if (welQ) begin
              strb.eraseReq  = 1'b1;
              strb.eraseKind = (cmdQ == OP_ERS) ? EK_SMALL :
                               (cmdQ == OP_ERM) ? EK_MID : EK_SECTOR;
            end else strb.errReq = 1'b1;
          end
        end
        ST_PROG: strb.advProg = 1'b1;
        ST_READ: strb.advRead = 1'b1;
        ST_FIXED: begin
          fixIdxD = fixNext;
          if (fixNext == fixLenQ) begin
            stateD  = ST_IDLE;
            fixIdxD = '0;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cmdQ    <= '0;
      needQ   <= '0;
      cntQ    <= '0;
      fixIdxQ <= '0;
      fixLenQ <= '0;
      welQ    <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cmdQ    <= cmdD;
      needQ   <= needD;
      cntQ    <= cntD;
      fixIdxQ <= fixIdxD;
      fixLenQ <= fixLenD;
      welQ    <= welD;
    end
  end
endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int unsigned DEV_SIZE = 1 << 20,
  parameter logic [7:0]  MFR_ID   = 8'h20,
  parameter logic [15:0] DEV_ID   = 16'hBA16,
  parameter logic [15:0] EXT_ID   = 16'h4D00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  seqStrobe_t        strb,
  input  logic              welQ,
  input  logic [7:0]        arrReadData,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [7:0]        txByte,
  output logic              progValid,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic              eraseValid,
  output logic [1:0]        eraseKind,
  output logic [ADDR_W-1:0] eraseAddr,
  output logic              errPulse
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEV_SIZE - 1);

  logic [ADDR_W-1:0] addrQ, shifted;
  logic [7:0]        idByte;

  assign shifted = {addrQ[ADDR_W-9:0], rxByte};
  assign arrAddr = addrQ;

  always_comb begin
    case (strb.fixIdx)
      3'd0:    idByte = MFR_ID;
      3'd1:    idByte = DEV_ID[15:8];
      3'd2:    idByte = DEV_ID[7:0];
      3'd3:    idByte = EXT_ID[15:8];
      default: idByte = EXT_ID[7:0];
    endcase
    case (strb.respSel)
      RS_ARRAY:  txByte = arrReadData;
      RS_STATUS: txByte = {6'b0, welQ, 1'b0};
      RS_ID:     txByte = idByte;
      default:   txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      progValid  <= 1'b0;
      progAddr   <= '0;
      progData   <= '0;
      eraseValid <= 1'b0;
      eraseKind  <= '0;
      eraseAddr  <= '0;
      errPulse   <= 1'b0;
    end else begin
      if (strb.shiftAddr)    addrQ <= shifted;
      else if (strb.advRead) addrQ <= (addrQ >= LAST) ? '0 : addrQ + 1'b1;
      else if (strb.advProg) addrQ <= addrQ + 1'b1;
      progValid <= strb.advProg;
      if (strb.advProg) begin
        progAddr <= addrQ;
        progData <= rxByte;
      end
      eraseValid <= strb.eraseReq;
      if (strb.eraseReq) begin
        eraseKind <= strb.eraseKind;
        eraseAddr <= (strb.eraseKind == EK_CHIP) ? '0 : shifted;
      end
      errPulse <= strb.errReq;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned DEV_SIZE = 1 << 20,
  parameter logic [7:0]  MFR_ID   = 8'h20,
  parameter logic [15:0] DEV_ID   = 16'hBA16,
  parameter logic [15:0] EXT_ID   = 16'h4D00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csAssert,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  output logic [7:0]  txByte,
  output logic [23:0] arrAddr,
  input  logic [7:0]  arrReadData,
  output logic        progValid,
  output logic [23:0] progAddr,
  output logic [7:0]  progData,
  output logic        eraseValid,
  output logic [1:0]  eraseKind,
  output logic [23:0] eraseAddr,
  output logic        errPulse
);
  seqState_e  seqState;
  logic       welQ;
  seqStrobe_t strb;

  flash_seq_ctrl #(.MFR_ID(MFR_ID), .HAS_EXT(EXT_ID != 16'h0)) i_ctrl (
    .clk(clk), .rstN(rstN), .csAssert(csAssert), .rxValid(rxValid),
    .rxByte(rxByte), .stateQ(seqState), .welQ(welQ), .strb(strb)
  );

  flash_seq_dp #(.DEV_SIZE(DEV_SIZE), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_ID(EXT_ID)) i_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .strb(strb), .welQ(welQ),
    .arrReadData(arrReadData), .arrAddr(arrAddr), .txByte(txByte),
    .progValid(progValid), .progAddr(progAddr), .progData(progData),
    .eraseValid(eraseValid), .eraseKind(eraseKind), .eraseAddr(eraseAddr),
    .errPulse(errPulse)
  );
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int unsigned DEV_SIZE = 1 << 20
) (
  input logic        clk,
  input logic        rstN,
  input logic        csAssert,
  input logic        rxValid,
  input logic [7:0]  rxByte,
  input logic [7:0]  txByte,
  input logic [23:0] arrAddr,
  input logic        progValid,
  input logic        eraseValid,
  input logic        errPulse,
  input seqState_e   seqState,
  input logic        welQ
);
  localparam logic [23:0] LAST = 24'(DEV_SIZE - 1);

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csAssert |=> (seqState == ST_IDLE));

  // R11
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState != ST_READ && seqState != ST_FIXED) |-> (txByte == 8'h00));

  // R7
  erase_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseValid |-> $past(welQ));

  // R5
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_READ && rxValid && !csAssert && arrAddr == LAST) |=> (arrAddr == 24'h0));

  // R6
  prog_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    progValid |-> $past(seqState == ST_PROG && rxValid && !csAssert));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progValid, eraseValid, errPulse}));

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_IDLE && rxValid && !csAssert && rxByte == 8'h06) |=> welQ);
endmodule

bind flash_cmd_seq flash_seq_chk #(.DEV_SIZE(DEV_SIZE)) i_chk (
  .clk(clk), .rstN(rstN), .csAssert(csAssert), .rxValid(rxValid), .rxByte(rxByte),
  .txByte(txByte), .arrAddr(arrAddr), .progValid(progValid), .eraseValid(eraseValid),
  .errPulse(errPulse), .seqState(seqState), .welQ(welQ)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
  localparam int DEV_SIZE = 1 << 20;
  localparam logic [7:0] MFR = 8'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csAssert = 1'b0, rxValid = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic [7:0]  txByte, arrReadData, progData;
  logic [23:0] arrAddr, progAddr, eraseAddr;
  logic        progValid, eraseValid, errPulse;
  logic [1:0]  eraseKind;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] patt(input int a);
    return 8'(a ^ (a >> 8) ^ (a >> 16) ^ 8'h5A);
  endfunction

  assign arrReadData = patt(int'(arrAddr));

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .csAssert(csAssert), .rxValid(rxValid), .rxByte(rxByte),
    .txByte(txByte), .arrAddr(arrAddr), .arrReadData(arrReadData),
    .progValid(progValid), .progAddr(progAddr), .progData(progData),
    .eraseValid(eraseValid), .eraseKind(eraseKind), .eraseAddr(eraseAddr),
    .errPulse(errPulse)
  );

  // behavioural reference: 0 idle, 1 collect, 2 program, 3 read, 4 fixed
  int mState = 0, mNeed = 0, mCnt = 0, mAddr = 0;
  logic [7:0] mCmd = 8'h00;
  bit mWel = 0;
  byte unsigned fixQ[$];
  bit eProg = 0, eErase = 0, eErr = 0;
  int eProgAddr = 0, eProgData = 0, eKind = 0, eEraseAddr = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int needOf(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32, 8'h20, 8'h52, 8'hD8: return 3;
      8'h0B, 8'h3B, 8'h6B: return 4;
      8'hBB: return (MFR == 8'hEF || MFR == 8'h01) ? 4 : 5;
      8'hEB: return (MFR == 8'hEF || MFR == 8'h01) ? 6 : 8;
      default: return 0;
    endcase
  endfunction

  task automatic modelEdge(input bit cs, input bit v, input logic [7:0] b);
    eProg = 0; eErase = 0; eErr = 0;
    if (cs) begin
      mState = 0; mCnt = 0; fixQ.delete();
    end else if (v) begin
      case (mState)
        0: begin
          mCmd = b; mCnt = 0;
          if (needOf(b) != 0) begin mNeed = needOf(b); mState = 1; end
          else if (b == 8'h01) begin
            if (mWel) begin mNeed = 1; mState = 1; end else eErr = 1;
          end
          else if (b == 8'h04) mWel = 0;
          else if (b == 8'h06) mWel = 1;
          else if (b == 8'h05) begin fixQ = {byte'(mWel ? 8'h02 : 8'h00)}; mState = 4; end
          else if (b == 8'h9F) begin fixQ = {8'h20, 8'hBA, 8'h16, 8'h4D, 8'h00}; mState = 4; end
          else if (b == 8'hC7) begin
            if (mWel) begin eErase = 1; eKind = 3; eEraseAddr = 0; end else eErr = 1;
          end
          else if (b != 8'h00) eErr = 1;
        end
        1: begin
          if (mCnt < 3) mAddr = ((mAddr << 8) | int'(b)) & 24'hFFFFFF;
          mCnt++;
          if (mCnt == mNeed) begin
            mState = 0;
            if (mCmd inside {8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB}) mState = 3;
            else if (mCmd inside {8'h02, 8'hA2, 8'h32}) mState = 2;
            else if (mCmd == 8'h01) mWel = 0;
            else if (mWel) begin
              eErase = 1; eEraseAddr = mAddr;
              eKind = (mCmd == 8'h20) ? 0 : (mCmd == 8'h52) ? 1 : 2;
            end else eErr = 1;
          end
        end
        2: begin
          eProg = 1; eProgAddr = mAddr; eProgData = int'(b);
          mAddr = (mAddr + 1) & 24'hFFFFFF;
        end
        3: mAddr = (mAddr >= DEV_SIZE - 1) ? 0 : mAddr + 1;
        default: begin
          void'(fixQ.pop_front());
          if (fixQ.size() == 0) mState = 0;
        end
      endcase
    end
  endtask

  task automatic step(input bit cs, input bit v, input logic [7:0] b, input string tag);
    int expTx;
    @(negedge clk);
    csAssert = cs; rxValid = v; rxByte = b;
    #1;
    expTx = (mState == 3) ? int'(patt(mAddr)) : (mState == 4) ? int'(fixQ[0]) : 0;
    chk(tag, "txByte", int'(txByte), expTx);
    chk(tag, "progValid", int'(progValid), int'(eProg));
    if (eProg) begin
      chk(tag, "progAddr", int'(progAddr), eProgAddr);
      chk(tag, "progData", int'(progData), eProgData);
    end
    chk(tag, "eraseValid", int'(eraseValid), int'(eErase));
    if (eErase) begin
      chk(tag, "eraseKind", int'(eraseKind), eKind);
      chk(tag, "eraseAddr", int'(eraseAddr), eEraseAddr);
    end
    chk(tag, "errPulse", int'(errPulse), int'(eErr));
    @(posedge clk);
    modelEdge(cs, v, b);
  endtask

  task automatic bytes(input string tag, input logic [7:0] q[$]);
    foreach (q[i]) step(0, 1, q[i], tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and status after reset
    idle("R1", 2);
    bytes("R1", '{8'h05, 8'h00});
    // R2 latch set/clear seen through status
    bytes("R2", '{8'h06, 8'h05, 8'h00, 8'h04, 8'h05, 8'h00});
    // R3 identification bytes and return to idle
    bytes("R3", '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    idle("R3", 1);
    // R5 read across the end of the device
    bytes("R5", '{8'h03, 8'h0F, 8'hFF, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00});
    step(1, 0, 8'h00, "R9");
    // R4 fast read with one dummy byte
    bytes("R4", '{8'h0B, 8'h00, 8'h01, 8'h00, 8'hAA, 8'h00, 8'h00});
    step(1, 0, 8'h00, "R4");
    bytes("R4", '{8'h3B, 8'h00, 8'h02, 8'h10, 8'h00, 8'h00});
    step(1, 0, 8'h00, "R4");
    bytes("R4", '{8'h6B, 8'h00, 8'h02, 8'h20, 8'h00, 8'h00});
    step(1, 0, 8'h00, "R4");
    // R4 dual I/O read: 5 bytes under this manufacturer
    bytes("R4", '{8'hBB, 8'h00, 8'h03, 8'h00, 8'h11, 8'h22, 8'h00, 8'h00});
    step(1, 0, 8'h00, "R4");
    // R4 quad I/O read: 8 bytes
    bytes("R4", '{8'hEB, 8'h00, 8'h04, 8'h00, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h00, 8'h00});
    step(1, 0, 8'h00, "R11");
    // R6 program stream
    bytes("R6", '{8'h06, 8'h02, 8'h00, 8'h10, 8'hFE, 8'hA1, 8'hB2, 8'hC3});
    step(1, 0, 8'h00, "R6");
    bytes("R6", '{8'h32, 8'h12, 8'h34, 8'h56, 8'h77});
    step(1, 0, 8'h00, "R6");
    // R7 erases with and without the latch
    bytes("R7", '{8'h20, 8'h01, 8'h23, 8'h45, 8'h52, 8'h0A, 8'hBC, 8'hDE, 8'hD8, 8'h0F, 8'h00, 8'h00});
    bytes("R7", '{8'hC7, 8'h04, 8'h20, 8'h00, 8'h00, 8'h00, 8'hC7});
    idle("R7", 1);
    // R8 write status clears the latch; refused without it
    bytes("R8", '{8'h06, 8'h01, 8'h55, 8'h05, 8'h00});
    bytes("R8", '{8'h01, 8'h05, 8'h00});
    // R9 abandon mid-command and ignore byte on chip-select cycle
    bytes("R9", '{8'h03, 8'h00});
    step(1, 0, 8'h00, "R9");
    bytes("R9", '{8'h05, 8'h00});
    step(1, 1, 8'h06, "R9");
    bytes("R9", '{8'h05, 8'h00});
    bytes("R9", '{8'h9F, 8'h00});
    step(1, 0, 8'h00, "R9");
    bytes("R9", '{8'h05, 8'h00});
    // R10 no-op and unknown opcodes
    bytes("R10", '{8'h00, 8'hFF, 8'h9E, 8'h00, 8'h05, 8'h00});
    idle("R10", 2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule